// File: doc/BRIEF.md
# Register Specifier Extension Decoder

This combinational block turns a short register operand taken from a 32-bit instruction word into a full register number. It covers the 128-entry integer, floating-point and condition-field files. A small extension tag carried in an instruction prefix supplies the missing bits. The tag also decides whether the operand names one scalar register or the first register of a vector run. The block returns the widened number and a vector flag.

Three operand kinds are handled. The first is an integer or floating-point register field, 5 bits wide. The second is a condition-bit operand, 5 bits wide, that addresses single bits inside the condition fields. The third is a condition-field operand, 3 bits wide. The tag is either 3 bits or 2 bits wide, chosen by a select input. A 2-bit tag trades reach for encoding space: scalars cover only the lower half of the file, and vectors start only on even registers. An all-zero tag leaves the operand as it would be without a prefix.

Top module: `reg_spec_widen`

## Requirements
- R1: Integer/FP kind (`kind_i` = 0), long tag (`short_i` = 0), tag bit 2 clear: the operand is scalar and `num_o` = tag[1:0]*32 + fld.
- R2: Integer/FP kind, long tag, tag bit 2 set: the operand is a vector and `num_o` = fld*4 + tag[1:0], so vector starts fall on any register in steps of 4.
- R3: Short tag (`short_i` = 1) uses only `tag_i[1:0]`, and `tag_i[2]` has no effect. The effective tag is {0,0,t0} when t1 = 0 and {1,t0,0} when t1 = 1. Scalars therefore reach only 0..63, and vector starts are always even.
- R4: An all-zero tag, long or short, gives `num_o` = fld for kind 0 and kind 1, with `vec_o` = 0.
- R5: Condition-bit kind (`kind_i` = 1), scalar: `num_o` = {0,0,e1,e0,fld[4:0]}, where e is the effective tag.
- R6: Condition-bit kind, vector: `num_o` = {fld[4:2], e1, e0, 0, 0, fld[1:0]}.
- R7: Condition-field kind (`kind_i` = 2) reads only fld[2:0]. Scalar gives {0,0,e1,e0,fld[2:0]} and vector gives {fld[2:0],e1,e0,0,0}. fld[4:3] has no effect.
- R8: `vec_o` equals bit 2 of the effective tag.
- R9: For every kind other than 1, `num_o[8:7]` = 0.
- R10: `kind_i` = 3 produces the same outputs as kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fld_i | input | 5 | Raw operand field from the instruction word |
| tag_i | input | 3 | Extension tag; only bits 1:0 are used with a short tag |
| short_i | input | 1 | 1 selects the 2-bit tag form |
| kind_i | input | 2 | 0 integer/FP, 1 condition bit, 2 condition field, 3 same as 0 |
| num_o | output | 9 | Widened register or condition-bit number |
| vec_o | output | 1 | 1 when the operand starts a vector |

## Verification
The bench sweeps every combination of field, tag, tag size and kind, and computes each expected number with multiply-and-add arithmetic. Three corner cases get particular attention.

- A short scalar tag of 01 must land in 32..63. A design that shifted the short tag before splitting it would land in 64..95 instead.
- The high field bits must be ignored for the condition-field kind. A design that failed to mask them would leak them into bits 7 and 8.
- Setting `tag_i[2]` with a short tag must change nothing. A design that read it would flip scalars into vectors.

// File: rtl/reg_spec_widen.sv
module reg_spec_widen #(
  parameter int FLD_W = 5,
  parameter int TAG_W = 3,
  parameter int OUT_W = 9
) (
  input  logic [FLD_W-1:0] fld_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             short_i,
  input  logic [1:0]       kind_i,
  output logic [OUT_W-1:0] num_o,
  output logic             vec_o
);
  localparam logic [1:0] K_CRBIT = 2'd1;
  localparam logic [1:0] K_CRFLD = 2'd2;

  logic [2:0] etag;
  logic [1:0] sel;
  logic [6:0] gpr_n;
  logic [8:0] crb_n;
  logic [6:0] crf_n;

  always_comb begin
    if (short_i) etag = tag_i[1] ? {1'b1, tag_i[0], 1'b0} : {2'b00, tag_i[0]};
    else         etag = tag_i;
  end

  assign sel   = etag[1:0];
  assign vec_o = etag[2];

  assign gpr_n = vec_o ? {fld_i, sel} : {sel, fld_i};
  assign crb_n = vec_o ? {fld_i[4:2], sel, 2'b00, fld_i[1:0]}
                       : {2'b00, sel, fld_i};
  assign crf_n = vec_o ? {fld_i[2:0], sel, 2'b00}
                       : {2'b00, sel, fld_i[2:0]};

  always_comb begin
    case (kind_i)
      K_CRBIT: num_o = crb_n;
      K_CRFLD: num_o = {2'b00, crf_n};
      default: num_o = {2'b00, gpr_n};
    endcase
  end

  always_comb begin
    a_r9_upper_zero: assert (kind_i == K_CRBIT || num_o[8:7] == 2'b00);
    a_r4_identity: assert (!(tag_i == 3'b000 && kind_i != K_CRFLD) || num_o == {4'b0000, fld_i});
    a_r3_short_scalar_range: assert (!(short_i && !tag_i[1] && kind_i != K_CRBIT && kind_i != K_CRFLD) || num_o < 9'd64);
    a_r3_short_vector_even: assert (!(short_i && tag_i[1] && kind_i != K_CRBIT && kind_i != K_CRFLD) || !num_o[0]);
    a_r8_vec_flag: assert (vec_o == (short_i ? tag_i[1] : tag_i[2]));
  end
endmodule

// File: tb/reg_spec_widen_tb.sv
module reg_spec_widen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] fld;
  logic [2:0] tag;
  logic       shrt;
  logic [1:0] kind;
  logic [8:0] num;
  logic       vec;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reg_spec_widen u_dut (
    .fld_i(fld), .tag_i(tag), .short_i(shrt), .kind_i(kind),
    .num_o(num), .vec_o(vec)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s fld=%0d tag=%0d short=%0d kind=%0d actual=%0d expected=%0d",
               req, fld, tag, shrt, kind, act, exp);
    end
  endtask

  initial begin
    fld = '0; tag = '0; shrt = 1'b0; kind = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", int'(num), 0);
    check("R8", int'(vec), 0);
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        for (int t = 0; t < 8; t++) begin
          for (int f = 0; f < 32; f++) begin
            int v, lo, e, b;
            string req;
            fld = 5'(f); tag = 3'(t); shrt = s[0]; kind = 2'(k);
            @(negedge clk);
            if (s == 1) begin
              v  = (t >> 1) & 1;
              lo = v ? (t & 1) * 2 : (t & 1);
            end else begin
              v  = t >> 2;
              lo = t & 3;
            end
            b = f & 7;
            if (k == 1) begin
              e   = v ? (f >> 2) * 64 + lo * 16 + (f & 3) : lo * 32 + f;
              req = v ? "R6" : "R5";
            end else if (k == 2) begin
              e   = v ? b * 16 + lo * 4 : lo * 8 + b;
              req = "R7";
            end else begin
              e   = v ? f * 4 + lo : lo * 32 + f;
              req = (k == 3) ? "R10" : (s == 1) ? "R3" : (v != 0) ? "R2" : "R1";
            end
            if ((t & (s ? 3 : 7)) == 0 && k != 2) req = "R4";
            check(req, int'(num), e);
            check("R8", int'(vec), v);
            if (k != 1) check("R9", int'(num[8:7]), 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule